// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block tracks address reservations for a fixed set of requesting contexts so that a load-reserved followed by a store-conditional behaves as one atomic step. It has three request inputs. A load-reserved request places a reservation for its context. A store request, either ordinary or conditional, is judged against the reservation table. Each request carries a context ID and a physical address. Before an address is stored or compared, its low `GRAN_LSB` bits are cleared, so reservations cover aligned granules of 2^GRAN_LSB bytes.

The table has one slot per context, and the context ID indexes the slot directly, so the table cannot overflow. A store is judged against the table as it stands before the current cycle's load-reserved. The verdict is registered in a small response state machine with four named states. `RSP_IDLE` means no response. `RSP_PLAIN` means an ordinary store was permitted. `RSP_SC_PASS` means a conditional store succeeded. `RSP_SC_FAIL` means a conditional store failed. On every clock the machine moves to `RSP_IDLE` when no store is presented, to `RSP_PLAIN` for an ordinary store, and to `RSP_SC_PASS` or `RSP_SC_FAIL` for a conditional store, depending on the table lookup. The outputs are decoded from this state. A permitted store clears every slot holding its granule. A failed conditional store changes nothing.

Top module: `resv_monitor`

## Requirements
- R1: After reset no context holds a reservation and `resp_valid` is 0.
- R2: An ordinary store (`st_cond`=0) is always permitted: one cycle later `resp_valid`=1, `resp_permit`=1, `resp_cond`=0, `resp_sc_ok`=0.
- R3: A load-reserved records a reservation for its context. A later conditional store from that context to the same granule succeeds, reported as `resp_cond`=1, `resp_permit`=1, `resp_sc_ok`=1.
- R4: A conditional store whose context holds no matching reservation fails, reported as `resp_cond`=1, `resp_permit`=0, `resp_sc_ok`=0.
- R5: Addresses are compared with their low GRAN_LSB bits cleared. With the default GRAN_LSB=4, addresses 0x200 and 0x20F match and 0x210 does not.
- R6: Each context holds at most one reservation. A new load-reserved from a context replaces its previous address.
- R7: A conditional store succeeds only when the context ID matches as well as the address. Another context's reservation on the granule does not count.
- R8: A permitted store, either ordinary or a successful conditional, removes every context's reservation on its granule.
- R9: A failed conditional store removes no reservation of any context.
- R10: A permitted store leaves reservations on other granules intact.
- R11: When a store and a load-reserved arrive in the same cycle, the store is judged and applied first. The new reservation survives even when it is on the store's granule.
- R12: The response appears exactly one cycle after the store request and lasts one cycle. With no store there is no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved request present |
| lr_ctx | input | CTX_W | Context of the load-reserved |
| lr_addr | input | ADDR_W | Address of the load-reserved |
| st_valid | input | 1 | Store request present |
| st_cond | input | 1 | 1 for a conditional store, 0 for an ordinary store |
| st_ctx | input | CTX_W | Context of the store |
| st_addr | input | ADDR_W | Address of the store |
| resp_valid | output | 1 | A store verdict is presented this cycle |
| resp_cond | output | 1 | The verdict belongs to a conditional store |
| resp_permit | output | 1 | The store may proceed |
| resp_sc_ok | output | 1 | Conditional store outcome: 1 success, 0 failure |

## Verification
The assertions assume that inputs are stable and defined at every rising edge, and that at most one load-reserved and one store arrive per cycle. They also assume that context IDs lie below NUM_CTX. The stability check on failed conditional stores holds only when no load-reserved arrives in the same cycle. The bench drives every input on the falling edge and uses only context IDs 0 to 3. It keeps load-reserved requests apart from failing conditional stores, except in the scenario that deliberately combines the two. In that scenario the stability property is not triggered, because its antecedent requires that no load-reserved is present.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_PLAIN   = 2'd1,
        RSP_SC_PASS = 2'd2,
        RSP_SC_FAIL = 2'd3
    } rsp_kind_t;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              kill_en,
    output logic              valid_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Store first, then load-reserved: a set wins over a kill in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr;
        end else if (kill_en) begin
            valid_q <= 1'b0;
        end
    end

    // R3 / R6: a load-reserved leaves exactly its granule in the slot
    assert_lr_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (valid_q && addr_q == $past(set_addr)));

    // R8: a permitted store on this granule without a same-cycle set empties the slot
    assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en && !set_en) |=> !valid_q);
endmodule

// File: rtl/resv_judge.sv
module resv_judge #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 32,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                           st_valid,
    input  logic                           st_cond,
    input  logic [CTX_W-1:0]               st_ctx,
    input  logic [ADDR_W-1:0]              st_gran,
    input  logic [NUM_CTX-1:0]             slot_valid,
    input  logic [NUM_CTX-1:0][ADDR_W-1:0] slot_addr,
    output logic                           own_hit,
    output logic                           permit,
    output logic [NUM_CTX-1:0]             kill_vec
);
    logic [NUM_CTX-1:0] hit_vec;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_cmp
        assign hit_vec[g] = slot_valid[g] && (slot_addr[g] == st_gran);
    end

    always_comb begin
        own_hit = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (st_ctx == CTX_W'(i)) own_hit = hit_vec[i];
        end
        // Conditional stores are presumed to fail until their own entry matches.
        permit   = !st_cond || own_hit;
        kill_vec = (st_valid && permit) ? hit_vec : '0;
    end
endmodule

// File: rtl/resv_resp.sv
module resv_resp
    import resv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_valid,
    input  logic st_cond,
    input  logic own_hit,
    output logic resp_valid,
    output logic resp_cond,
    output logic resp_permit,
    output logic resp_sc_ok
);
    rsp_kind_t state_q, state_d;

    always_comb begin
        state_d = RSP_IDLE;
        if (st_valid) begin
            if (!st_cond)     state_d = RSP_PLAIN;
            else if (own_hit) state_d = RSP_SC_PASS;
            else              state_d = RSP_SC_FAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        resp_valid  = 1'b0;
        resp_cond   = 1'b0;
        resp_permit = 1'b0;
        resp_sc_ok  = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_PLAIN: begin
                resp_valid  = 1'b1;
                resp_permit = 1'b1;
            end
            RSP_SC_PASS: begin
                resp_valid  = 1'b1;
                resp_cond   = 1'b1;
                resp_permit = 1'b1;
                resp_sc_ok  = 1'b1;
            end
            RSP_SC_FAIL: begin
                resp_valid = 1'b1;
                resp_cond  = 1'b1;
            end
        endcase
    end

    // R2: ordinary stores are always permitted
    assert_plain_permit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_cond) |=> (resp_valid && resp_permit && !resp_cond));

    // R12: no store, no response
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !resp_valid);

    // R4: a conditional outcome always matches its permit
    assert_sc_consistent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_cond |-> (resp_sc_ok == resp_permit));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int NUM_CTX  = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 4,
    localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [CTX_W-1:0]  lr_ctx,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              st_valid,
    input  logic              st_cond,
    input  logic [CTX_W-1:0]  st_ctx,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              resp_valid,
    output logic              resp_cond,
    output logic              resp_permit,
    output logic              resp_sc_ok
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

    logic [ADDR_W-1:0]              lr_gran, st_gran;
    logic [NUM_CTX-1:0]             slot_valid, kill_vec;
    logic [NUM_CTX-1:0][ADDR_W-1:0] slot_addr;
    logic                           own_hit, permit;

    assign lr_gran = lr_addr & GRAN_MASK;
    assign st_gran = st_addr & GRAN_MASK;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        resv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (lr_valid && (lr_ctx == CTX_W'(g))),
            .set_addr (lr_gran),
            .kill_en  (kill_vec[g]),
            .valid_q  (slot_valid[g]),
            .addr_q   (slot_addr[g])
        );
    end

    resv_judge #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_judge (
        .st_valid   (st_valid),
        .st_cond    (st_cond),
        .st_ctx     (st_ctx),
        .st_gran    (st_gran),
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .own_hit    (own_hit),
        .permit     (permit),
        .kill_vec   (kill_vec)
    );

    resv_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid    (st_valid),
        .st_cond     (st_cond),
        .own_hit     (own_hit),
        .resp_valid  (resp_valid),
        .resp_cond   (resp_cond),
        .resp_permit (resp_permit),
        .resp_sc_ok  (resp_sc_ok)
    );

    // R9: a failed conditional store leaves the whole table untouched
    assert_fail_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_cond && !own_hit && !lr_valid) |=> ($stable(slot_valid) && $stable(slot_addr)));

    // R7: success needs a slot of the storing context
    assert_sc_needs_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_cond && !slot_valid[st_ctx]) |=> !resp_sc_ok);
endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int NUM_CTX = 4;
    localparam int ADDR_W  = 32;
    localparam int CTX_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lr_valid = 1'b0, st_valid = 1'b0, st_cond = 1'b0;
    logic [CTX_W-1:0]  lr_ctx = '0, st_ctx = '0;
    logic [ADDR_W-1:0] lr_addr = '0, st_addr = '0;
    logic              resp_valid, resp_cond, resp_permit, resp_sc_ok;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    resv_monitor #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_LSB(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_ctx(lr_ctx), .lr_addr(lr_addr),
        .st_valid(st_valid), .st_cond(st_cond), .st_ctx(st_ctx), .st_addr(st_addr),
        .resp_valid(resp_valid), .resp_cond(resp_cond),
        .resp_permit(resp_permit), .resp_sc_ok(resp_sc_ok)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,cond,permit,ok} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] resp();
        return {resp_valid, resp_cond, resp_permit, resp_sc_ok};
    endfunction

    task automatic lr(input int c, input logic [31:0] a);
        @(negedge clk);
        lr_valid = 1'b1; lr_ctx = CTX_W'(c); lr_addr = a;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    // Store request; verdict is registered at the next edge and sampled at the following falling edge.
    task automatic store(input string req, input int c, input logic [31:0] a,
                         input logic cond, input logic [3:0] exp);
        @(negedge clk);
        st_valid = 1'b1; st_cond = cond; st_ctx = CTX_W'(c); st_addr = a;
        @(negedge clk);
        st_valid = 1'b0;
        check(req, resp(), exp);
    endtask

    localparam logic [3:0] PLAIN = 4'b1010;
    localparam logic [3:0] PASS  = 4'b1111;
    localparam logic [3:0] FAILV = 4'b1100;

    task automatic t_reset();
        check("R1 idle after reset", resp(), 4'b0000);
        for (int c = 0; c < NUM_CTX; c++) store("R1 no reservation", c, 32'h0, 1'b1, FAILV);
        store("R4 sc without lr", 2, 32'h40, 1'b1, FAILV);
    endtask

    task automatic t_plain();
        store("R2 plain store", 1, 32'h1234, 1'b0, PLAIN);
        @(negedge clk);
        check("R12 one-cycle response", resp(), 4'b0000);
    endtask

    task automatic t_lr_sc();
        lr(1, 32'h100);
        store("R3 sc after lr", 1, 32'h10C, 1'b1, PASS);
        store("R8 own success clears", 1, 32'h100, 1'b1, FAILV);
    endtask

    task automatic t_granule();
        lr(2, 32'h200);
        store("R5 next granule misses", 2, 32'h210, 1'b1, FAILV);
        store("R5 same granule hits", 2, 32'h20F, 1'b1, PASS);
    endtask

    task automatic t_replace();
        lr(0, 32'h300);
        lr(0, 32'h400);
        store("R6 old address dropped", 0, 32'h300, 1'b1, FAILV);
        store("R6 new address held", 0, 32'h400, 1'b1, PASS);
    endtask

    task automatic t_ctx();
        lr(1, 32'h500);
        store("R7 other context fails", 3, 32'h500, 1'b1, FAILV);
        store("R9 failed sc kept reservation", 1, 32'h500, 1'b1, PASS);
    endtask

    task automatic t_clear_all();
        lr(0, 32'h600); lr(1, 32'h600); lr(2, 32'h600); lr(3, 32'h700);
        store("R2 plain store permitted", 3, 32'h608, 1'b0, PLAIN);
        store("R8 ctx0 cleared by plain store", 0, 32'h600, 1'b1, FAILV);
        store("R8 ctx1 cleared by plain store", 1, 32'h600, 1'b1, FAILV);
        store("R8 ctx2 cleared by plain store", 2, 32'h600, 1'b1, FAILV);
        store("R10 other granule intact", 3, 32'h700, 1'b1, PASS);
    endtask

    task automatic t_sc_clears_others();
        lr(0, 32'h800); lr(1, 32'h800);
        store("R8 first sc passes", 0, 32'h800, 1'b1, PASS);
        store("R8 peer cleared by sc", 1, 32'h800, 1'b1, FAILV);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lr_valid = 1'b1; lr_ctx = 2'd2; lr_addr = 32'h900;
        st_valid = 1'b1; st_cond = 1'b0; st_ctx = 2'd0; st_addr = 32'h900;
        @(negedge clk);
        lr_valid = 1'b0; st_valid = 1'b0;
        check("R11 plain store alongside lr", resp(), PLAIN);
        store("R11 lr survives same-cycle store", 2, 32'h900, 1'b1, PASS);
        @(negedge clk);
        lr_valid = 1'b1; lr_ctx = 2'd1; lr_addr = 32'hA00;
        st_valid = 1'b1; st_cond = 1'b1; st_ctx = 2'd1; st_addr = 32'hA00;
        @(negedge clk);
        lr_valid = 1'b0; st_valid = 1'b0;
        check("R11 sc judged before same-cycle lr", resp(), FAILV);
        store("R11 lr recorded after sc", 1, 32'hA00, 1'b1, PASS);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_lr_sc();
        t_granule();
        t_replace();
        t_ctx();
        t_clear_all();
        t_sc_clears_others();
        t_same_cycle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule